// File: doc/BRIEF.md
# Power Standby Request Controller

This block decides when a chip asks its external power-management IC to enter standby. It holds a small set of configuration registers behind a write/read port that also carries the requester's privilege level, security state and domain number. One registered level output, `stby_req`, is the standby request. It is driven either by software pulses or by hardware conditions. Which hardware conditions apply depends on a programmable control mode.

In CPU-mode control, the block watches the low-power state of one selected domain out of several. Separate enables decide whether WAIT, STOP or SUSPEND requests standby. In setpoint control, two masks are indexed by the current system setpoint. One mask requests standby whenever its bit is set. The other requests standby only while the system is also in standby. In the idle mode, and in the reserved mode, hardware conditions are ignored and only the software pulses move the output.

Writes are filtered by permission bits and an allow-list of domain numbers. Three sticky lock bits freeze the permissions, the allow-list and the trigger configuration. A write that is refused leaves every register as it was and raises a one-cycle error flag.

Top module: `pwr_stby_ctrl`

## Requirements
- R1: After a synchronous reset, every register field, `stby_req`, `reg_rdata` and `wr_err` are zero.
- R2: Register map, read back on `reg_rdata` one clock after `reg_addr` is presented (reads are never refused):
  - Address 0: bit0 user-access allowed, bit1 non-secure-access allowed, bit2 permission lock, bits[7:4] domain allow-list (bit 4+d for domain d), bit8 list lock, bit9 configuration lock.
  - Address 1: bits[1:0] control mode, bits[5:4] watched domain.
  - Address 2: bit0 WAIT enable, bit1 STOP enable, bit2 SUSPEND enable, bit4 software-on pulse, bit5 software-off pulse. Bits 4 and 5 always read 0.
  - Address 3: bits[15:0] active mask, bits[31:16] sleep mask.
- R3: A write is refused under any of these conditions:
  - `req_user`=1 while the user bit is 0;
  - `req_nonsec`=1 while the non-secure bit is 0;
  - the allow-list is non-zero and bit `req_dom` of it is 0.

  An all-zero allow-list places no domain restriction.
- R4: A refused write changes no register. `wr_err` is 1 for exactly the cycle after the refused write's clock edge.
- R5: While the configuration lock is 1, a write is refused if it would change any of the following:
  - the control mode;
  - the WAIT/STOP/SUSPEND enables;
  - either setpoint mask.

  The watched domain and the software pulses stay writable.
- R6: While the permission lock is 1, a write that would change the user or non-secure bit is refused. While the list lock is 1, a write that would change the allow-list is refused.
- R7: Lock bits are sticky: a write of 0 to a set lock bit leaves it at 1 and is not by itself an error. Only reset clears them.
- R8: In control mode 01, `stby_req` is 1 after a clock edge exactly when the watched domain's power state at that edge has its enable set. The power state is taken from `cpu_pm` bits [2d+1:2d], where 00=run, 01=WAIT, 10=STOP and 11=SUSPEND.
- R9: In control mode 10, `stby_req` becomes (active[sp] OR (sleep[sp] AND `sys_stby`)), where sp is `setpoint`.
- R10: In control modes 00 and 11, hardware conditions are ignored and `stby_req` holds its value. An accepted write with bit4 set at address 2 sets `stby_req` at that write's edge.
- R11: An accepted write with bit5 set at address 2 clears `stby_req` at that edge, winning over bit4. The pulses last one edge only, after which the active mode's hardware evaluation resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 32 | Write data |
| req_user | input | 1 | Requester is in user mode |
| req_nonsec | input | 1 | Requester is non-secure |
| req_dom | input | 2 | Requester domain number |
| cpu_pm | input | 8 | Power state of each domain, 2 bits per domain |
| setpoint | input | 4 | Current system setpoint |
| sys_stby | input | 1 | System is in standby |
| reg_rdata | output | 32 | Registered read data |
| wr_err | output | 1 | One-cycle pulse after a refused write |
| stby_req | output | 1 | Registered standby request level |

## Verification
In CPU-mode control, the watched domain is walked through WAIT, STOP and SUSPEND with only some enables set. A neighbouring domain is also put into WAIT. Together these separate the per-state enables from each other and show that domain selection actually picks the watched domain. In setpoint control, the setpoint is moved between an active-mask bit, a sleep-mask bit with and without system standby, and an unset bit. This separates the two masks and the standby qualifier. Write attempts are varied in privilege, security and domain against each permission bit and each lock. Locked fields are written both with their current value and with a different one, so an over-strict lock can be told apart from a missing one.

// File: rtl/pss_pkg.sv
`timescale 1ns/1ps
package pss_pkg;
  typedef enum logic [1:0] {
    MODE_NONE  = 2'b00,
    MODE_CPU   = 2'b01,
    MODE_SETPT = 2'b10,
    MODE_RSVD  = 2'b11
  } ctl_mode_e;

  typedef enum logic [1:0] {
    PM_RUN  = 2'b00,
    PM_WAIT = 2'b01,
    PM_STOP = 2'b10,
    PM_SUSP = 2'b11
  } cpu_pm_e;

  localparam int ADDR_W      = 2;
  localparam logic [ADDR_W-1:0] A_ACCESS = 2'd0;
  localparam logic [ADDR_W-1:0] A_MODE   = 2'd1;
  localparam logic [ADDR_W-1:0] A_CPUTRG = 2'd2;
  localparam logic [ADDR_W-1:0] A_SPMASK = 2'd3;

  localparam int B_USER    = 0;
  localparam int B_NONSEC  = 1;
  localparam int B_LKPERM  = 2;
  localparam int B_LIST    = 4;
  localparam int B_EN_WAIT = 0;
  localparam int B_EN_STOP = 1;
  localparam int B_EN_SUSP = 2;
  localparam int B_SW_ON   = 4;
  localparam int B_SW_OFF  = 5;
  localparam int B_DOMSEL  = 4;
endpackage

// File: rtl/pss_regs.sv
`timescale 1ns/1ps
module pss_regs
  import pss_pkg::*;
#(
  parameter int N_DOM = 4,
  parameter int N_SP  = 16,
  parameter int DW    = 32,
  localparam int DOM_W = $clog2(N_DOM),
  localparam int B_LKLIST = B_LIST + N_DOM,
  localparam int B_LKCFG  = B_LIST + N_DOM + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic              req_user,
  input  logic              req_nonsec,
  input  logic [DOM_W-1:0]  req_dom,
  output logic [DW-1:0]     reg_rdata,
  output logic              wr_err,
  output logic [1:0]        mode,
  output logic [DOM_W-1:0]  dom_sel,
  output logic [2:0]        pm_en,
  output logic [N_SP-1:0]   act_mask,
  output logic [N_SP-1:0]   slp_mask,
  output logic              sw_on,
  output logic              sw_off,
  output logic              lk_perm,
  output logic              lk_list,
  output logic              lk_cfg,
  output logic              user_ok,
  output logic              nonsec_ok,
  output logic [N_DOM-1:0]  dom_list
);
  logic perm_ok, lock_hit, wr_ok;
  logic [DW-1:0] rd_mux;

  always_comb begin
    perm_ok = (!req_user || user_ok) && (!req_nonsec || nonsec_ok) &&
              ((dom_list == '0) || dom_list[req_dom]);
  end

  always_comb begin
    lock_hit = 1'b0;
    unique case (reg_addr)
      A_ACCESS: lock_hit =
        (lk_perm && ((reg_wdata[B_USER] != user_ok) || (reg_wdata[B_NONSEC] != nonsec_ok))) ||
        (lk_list && (reg_wdata[B_LIST +: N_DOM] != dom_list));
      A_MODE:   lock_hit = lk_cfg && (reg_wdata[1:0] != mode);
      A_CPUTRG: lock_hit = lk_cfg && (reg_wdata[2:0] != pm_en);
      default:  lock_hit = lk_cfg && ((reg_wdata[N_SP-1:0] != act_mask) ||
                                      (reg_wdata[2*N_SP-1:N_SP] != slp_mask));
    endcase
  end

  assign wr_ok  = reg_wr && perm_ok && !lock_hit;
  assign sw_on  = wr_ok && (reg_addr == A_CPUTRG) && reg_wdata[B_SW_ON];
  assign sw_off = wr_ok && (reg_addr == A_CPUTRG) && reg_wdata[B_SW_OFF];

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr)
      A_ACCESS: begin
        rd_mux[B_USER]           = user_ok;
        rd_mux[B_NONSEC]         = nonsec_ok;
        rd_mux[B_LKPERM]         = lk_perm;
        rd_mux[B_LIST +: N_DOM]  = dom_list;
        rd_mux[B_LKLIST]         = lk_list;
        rd_mux[B_LKCFG]          = lk_cfg;
      end
      A_MODE: begin
        rd_mux[1:0]                = mode;
        rd_mux[B_DOMSEL +: DOM_W]  = dom_sel;
      end
      A_CPUTRG: rd_mux[2:0] = pm_en;
      default:  rd_mux[2*N_SP-1:0] = {slp_mask, act_mask};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      wr_err    <= 1'b0;
      mode      <= '0;
      dom_sel   <= '0;
      pm_en     <= '0;
      act_mask  <= '0;
      slp_mask  <= '0;
      lk_perm   <= 1'b0;
      lk_list   <= 1'b0;
      lk_cfg    <= 1'b0;
      user_ok   <= 1'b0;
      nonsec_ok <= 1'b0;
      dom_list  <= '0;
    end else begin
      reg_rdata <= rd_mux;
      wr_err    <= reg_wr && !wr_ok;
      if (wr_ok) begin
        unique case (reg_addr)
          A_ACCESS: begin
            user_ok   <= reg_wdata[B_USER];
            nonsec_ok <= reg_wdata[B_NONSEC];
            dom_list  <= reg_wdata[B_LIST +: N_DOM];
            lk_perm   <= lk_perm | reg_wdata[B_LKPERM];
            lk_list   <= lk_list | reg_wdata[B_LKLIST];
            lk_cfg    <= lk_cfg  | reg_wdata[B_LKCFG];
          end
          A_MODE: begin
            mode    <= reg_wdata[1:0];
            dom_sel <= reg_wdata[B_DOMSEL +: DOM_W];
          end
          A_CPUTRG: pm_en <= reg_wdata[2:0];
          default: begin
            act_mask <= reg_wdata[N_SP-1:0];
            slp_mask <= reg_wdata[2*N_SP-1:N_SP];
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/pss_trig.sv
`timescale 1ns/1ps
module pss_trig
  import pss_pkg::*;
#(
  parameter int N_DOM = 4,
  parameter int N_SP  = 16,
  localparam int DOM_W = $clog2(N_DOM),
  localparam int SP_W  = $clog2(N_SP)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mode,
  input  logic [DOM_W-1:0]   dom_sel,
  input  logic [2*N_DOM-1:0] cpu_pm,
  input  logic [2:0]         pm_en,
  input  logic [SP_W-1:0]    setpoint,
  input  logic               sys_stby,
  input  logic [N_SP-1:0]    act_mask,
  input  logic [N_SP-1:0]    slp_mask,
  input  logic               sw_on,
  input  logic               sw_off,
  output logic               stby_req
);
  logic [1:0] dom_pm [N_DOM];
  logic [1:0] sel_pm;
  logic       cpu_hit, sp_hit;

  for (genvar g = 0; g < N_DOM; g++) begin : g_dom
    assign dom_pm[g] = cpu_pm[2*g +: 2];
  end

  assign sel_pm = dom_pm[dom_sel];

  always_comb begin
    unique case (sel_pm)
      PM_WAIT: cpu_hit = pm_en[B_EN_WAIT];
      PM_STOP: cpu_hit = pm_en[B_EN_STOP];
      PM_SUSP: cpu_hit = pm_en[B_EN_SUSP];
      default: cpu_hit = 1'b0;
    endcase
    sp_hit = act_mask[setpoint] | (slp_mask[setpoint] & sys_stby);
  end

  always_ff @(posedge clk) begin
    if (rst)                    stby_req <= 1'b0;
    else if (sw_off)            stby_req <= 1'b0;
    else if (sw_on)             stby_req <= 1'b1;
    else if (mode == MODE_CPU)  stby_req <= cpu_hit;
    else if (mode == MODE_SETPT) stby_req <= sp_hit;
  end
endmodule

// File: rtl/pwr_stby_ctrl.sv
`timescale 1ns/1ps
module pwr_stby_ctrl
  import pss_pkg::*;
#(
  parameter int N_DOM = 4,
  parameter int N_SP  = 16,
  parameter int DW    = 32,
  localparam int DOM_W = $clog2(N_DOM),
  localparam int SP_W  = $clog2(N_SP),
  localparam int CFG_W = 2 + DOM_W + 3 + 2*N_SP + 5 + N_DOM
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  input  logic               req_user,
  input  logic               req_nonsec,
  input  logic [DOM_W-1:0]   req_dom,
  input  logic [2*N_DOM-1:0] cpu_pm,
  input  logic [SP_W-1:0]    setpoint,
  input  logic               sys_stby,
  output logic [DW-1:0]      reg_rdata,
  output logic               wr_err,
  output logic               stby_req
);
  logic [1:0]       mode;
  logic [DOM_W-1:0] dom_sel;
  logic [2:0]       pm_en;
  logic [N_SP-1:0]  act_mask, slp_mask;
  logic             sw_on, sw_off;
  logic             lk_perm, lk_list, lk_cfg, user_ok, nonsec_ok;
  logic [N_DOM-1:0] dom_list;
  logic [CFG_W-1:0] cfg_word;

  assign cfg_word = {mode, dom_sel, pm_en, act_mask, slp_mask,
                     lk_perm, lk_list, lk_cfg, user_ok, nonsec_ok, dom_list};

  pss_regs #(.N_DOM(N_DOM), .N_SP(N_SP), .DW(DW)) u_regs (
    .clk, .rst, .reg_wr, .reg_addr, .reg_wdata, .req_user, .req_nonsec, .req_dom,
    .reg_rdata, .wr_err, .mode, .dom_sel, .pm_en, .act_mask, .slp_mask,
    .sw_on, .sw_off, .lk_perm, .lk_list, .lk_cfg, .user_ok, .nonsec_ok, .dom_list
  );

  pss_trig #(.N_DOM(N_DOM), .N_SP(N_SP)) u_trig (
    .clk, .rst, .mode, .dom_sel, .cpu_pm, .pm_en, .setpoint, .sys_stby,
    .act_mask, .slp_mask, .sw_on, .sw_off, .stby_req
  );
endmodule

// File: rtl/pwr_stby_ctrl_chk.sv
`timescale 1ns/1ps
module pwr_stby_ctrl_chk #(
  parameter int N_SP  = 16,
  parameter int CFG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic             wr_err,
  input logic             stby_req,
  input logic [1:0]       mode,
  input logic [2:0]       pm_en,
  input logic [N_SP-1:0]  act_mask,
  input logic [N_SP-1:0]  slp_mask,
  input logic             lk_perm,
  input logic             lk_list,
  input logic             lk_cfg,
  input logic [CFG_W-1:0] cfg_word
);
  // R4
  rej_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> $stable(cfg_word));
  // R4
  err_src_chk: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> $past(reg_wr));
  // R7
  cfg_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(lk_cfg) |-> lk_cfg);
  // R7
  perm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(lk_perm) |-> lk_perm);
  // R7
  list_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(lk_list) |-> lk_list);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 && !reg_wr) |=> $stable(stby_req));
  // R8
  cpu_noen_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && !reg_wr && pm_en == 3'b000) |=> !stby_req);
  // R9
  sp_nomask_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && !reg_wr && act_mask == '0 && slp_mask == '0) |=> !stby_req);
endmodule

bind pwr_stby_ctrl pwr_stby_ctrl_chk #(.N_SP(N_SP), .CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .wr_err(wr_err), .stby_req(stby_req),
  .mode(mode), .pm_en(pm_en), .act_mask(act_mask), .slp_mask(slp_mask),
  .lk_perm(lk_perm), .lk_list(lk_list), .lk_cfg(lk_cfg), .cfg_word(cfg_word)
);

// File: tb/tb_pwr_stby_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_stby_ctrl;
  typedef struct {
    bit ck_s; bit s; bit ck_e; bit e; bit ck_r; logic [31:0] r; string req;
  } exp_t;

  logic clk = 0, rst = 1;
  logic reg_wr = 0, req_user = 0, req_nonsec = 0, sys_stby = 0;
  logic [1:0] reg_addr = 0, req_dom = 0;
  logic [31:0] reg_wdata = 0;
  logic [7:0] cpu_pm = 0;
  logic [3:0] setpoint = 0;
  logic [31:0] reg_rdata;
  logic wr_err, stby_req;

  logic [7:0] n_cm = 0;
  logic [3:0] n_sp = 0;
  logic       n_ss = 0;
  int tests = 0, fails = 0;
  bit done = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  pwr_stby_ctrl dut (
    .clk, .rst, .reg_wr, .reg_addr, .reg_wdata, .req_user, .req_nonsec, .req_dom,
    .cpu_pm, .setpoint, .sys_stby, .reg_rdata, .wr_err, .stby_req
  );

  function automatic exp_t ex(bit cs, bit s, bit ce, bit e, bit cr, logic [31:0] r, string req);
    exp_t x;
    x.ck_s = cs; x.s = s; x.ck_e = ce; x.e = e; x.ck_r = cr; x.r = r; x.req = req;
    return x;
  endfunction

  task automatic step(bit wr, logic [1:0] a, logic [31:0] d, bit u, bit ns, logic [1:0] dm, exp_t x);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    req_user = u; req_nonsec = ns; req_dom = dm;
    cpu_pm = n_cm; setpoint = n_sp; sys_stby = n_ss;
    q.push_back(x);
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] v, string req);
    step(0, a, 0, 0, 0, 0, ex(0, 0, 1, 0, 1, v, req));
  endtask

  task automatic idle_s(bit s, string req);
    step(0, 0, 0, 0, 0, 0, ex(1, s, 1, 0, 0, 0, req));
  endtask

  task automatic wr_e(logic [1:0] a, logic [31:0] d, logic [1:0] dm, bit u, bit ns, bit e, string req);
    step(1, a, d, u, ns, dm, ex(0, 0, 1, e, 0, 0, req));
  endtask

  task automatic wr_se(logic [1:0] a, logic [31:0] d, bit s, bit e, string req);
    step(1, a, d, 0, 0, 1, ex(1, s, 1, e, 0, 0, req));
  endtask

  // monitor: compares one expectation per clock, 5 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        if (x.ck_s) begin
          tests++;
          if (stby_req !== x.s) begin
            fails++;
            $display("FAIL %s stby_req act=%0b exp=%0b", x.req, stby_req, x.s);
          end
        end
        if (x.ck_e) begin
          tests++;
          if (wr_err !== x.e) begin
            fails++;
            $display("FAIL %s wr_err act=%0b exp=%0b", x.req, wr_err, x.e);
          end
        end
        if (x.ck_r) begin
          tests++;
          if (reg_rdata !== x.r) begin
            fails++;
            $display("FAIL %s rdata act=%h exp=%h", x.req, reg_rdata, x.r);
          end
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    step(0, 0, 0, 0, 0, 0, ex(1, 0, 1, 0, 1, 0, "R1"));
    // R3 empty allow-list: any domain may write
    wr_e(1, 32'h21, 0, 0, 0, 0, "R3");
    wr_e(2, 32'h05, 0, 0, 0, 0, "R3");
    rd(1, 32'h21, "R2");
    // R8 cpu-mode triggers on domain 2
    n_cm = 8'h10; idle_s(1, "R8_wait");
    rd(2, 32'h05, "R2");
    n_cm = 8'h20; idle_s(0, "R8_stop_disabled");
    n_cm = 8'h01; idle_s(0, "R8_other_domain");
    n_cm = 8'h30; idle_s(1, "R8_suspend");
    // R11 off pulse, then hardware resumes
    wr_se(2, 32'h25, 0, 0, "R11_off");
    idle_s(1, "R11_selfclear");
    // R9 setpoint masks
    wr_e(3, 32'h0020_0008, 0, 0, 0, 0, "R9");
    wr_e(1, 32'h22, 0, 0, 0, 0, "R9");
    n_sp = 3; idle_s(1, "R9_active");
    n_sp = 5; n_ss = 0; idle_s(0, "R9_sleep_no_stby");
    n_ss = 1; idle_s(1, "R9_sleep_stby");
    n_sp = 7; idle_s(0, "R9_unset");
    // R10 idle mode with software pulses
    wr_se(1, 32'h20, 0, 0, "R10");
    wr_se(2, 32'h15, 1, 0, "R10_on");
    n_sp = 3; n_cm = 8'h30; n_ss = 0; idle_s(1, "R10_hold");
    n_sp = 7; n_cm = 8'h00; idle_s(1, "R10_hold");
    wr_se(2, 32'h35, 0, 0, "R11_off_wins");
    idle_s(0, "R11_hold_off");
    // R3 access checks
    wr_e(0, 32'h20, 0, 0, 0, 0, "R3_list_set");
    wr_e(1, 32'h30, 0, 0, 0, 1, "R3_dom_refused");
    rd(1, 32'h20, "R4_unchanged");
    wr_e(1, 32'h30, 1, 1, 0, 1, "R3_user_refused");
    wr_e(1, 32'h30, 1, 0, 1, 1, "R3_nonsec_refused");
    idle_s(0, "R4_err_one_cycle");
    wr_e(1, 32'h30, 1, 0, 0, 0, "R3_allowed");
    rd(1, 32'h30, "R2");
    wr_e(0, 32'h21, 1, 0, 0, 0, "R3");
    wr_e(1, 32'h20, 1, 1, 0, 0, "R3_user_allowed");
    // R5 configuration lock
    wr_e(0, 32'h221, 1, 0, 0, 0, "R5_lock");
    wr_e(1, 32'h21, 1, 0, 0, 1, "R5_mode_locked");
    rd(1, 32'h20, "R5");
    wr_e(1, 32'h30, 1, 0, 0, 0, "R5_domsel_free");
    wr_e(3, 32'h0, 1, 0, 0, 1, "R5_mask_locked");
    rd(3, 32'h0020_0008, "R5");
    // R7 sticky
    wr_e(0, 32'h021, 1, 0, 0, 0, "R7");
    rd(0, 32'h221, "R7");
    wr_se(2, 32'h15, 1, 0, "R5_pulse_free");
    wr_se(2, 32'h14, 1, 1, "R5_enable_locked");
    // R6 permission and list locks
    wr_e(0, 32'h225, 1, 0, 0, 0, "R6");
    wr_e(0, 32'h224, 1, 0, 0, 1, "R6_perm_locked");
    wr_e(0, 32'h325, 1, 0, 0, 0, "R6");
    wr_e(0, 32'h335, 1, 0, 0, 1, "R6_list_locked");
    rd(0, 32'h325, "R6");
    wait (q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule